// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Alignment Unit

This block sits between the register read stage and a 32-bit byte-addressed data memory. For each load or store request it forms the effective address from a base register value and an offset. The offset is either a zero-extended immediate or a second register value, and it can be added or subtracted. The block then chooses between three indexing styles: plain base-plus-offset, pre-indexed with base update, and post-indexed with base update. It also produces the updated base value and its write strobe for the register file.

On the data side it converts between register form and the byte lanes of a 32-bit memory word. Store data is replicated across the lanes and only the addressed lanes are enabled. Load data coming back from memory is shifted down from the addressed lane and zero-extended. The mapping of addresses to lanes follows a byte-order setting that is captured while reset is held and stays fixed afterwards. An access whose address does not match its size raises an alignment error, and that access then enables no lanes and writes no memory or base register.

All request results are registered, so they appear one clock after the request. Load extraction is a combinational function of the returned memory word and the access currently shown on the address outputs.

Top module: `mem_access_align`

## Requirements
- R1: While reset is low and at the first cycle after it, out_valid, mem_be, mem_we, base_wb_en and align_err are all 0.
- R2: A request sampled with req_valid=1 at a rising edge shows its results on the outputs after that edge with out_valid=1. A cycle without a request gives out_valid=0, mem_be=0, mem_we=0 and base_wb_en=0.
- R3: With pre_index=1 and writeback=0, mem_addr is base_val plus or minus the offset, and base_wb_en is 0.
- R4: With pre_index=1 and writeback=1, mem_addr and base_wb_val are both base_val plus or minus the offset, and base_wb_en is 1.
- R5: With pre_index=0 (post-indexed), mem_addr equals base_val unchanged, base_wb_val is base_val plus or minus the offset, and base_wb_en is 1 whatever the writeback input holds.
- R6: off_is_reg=1 selects off_reg as the offset. off_is_reg=0 selects off_imm zero-extended to 32 bits. off_sub=1 subtracts the offset and off_sub=0 adds it. Arithmetic wraps modulo 2^32.
- R7: req_size encodes 00 byte, 01 halfword, 10 word (11 acts as word). A store drives mem_we=1 and replicates the byte into all four lanes, or the halfword into both halves. mem_be enables 1, 2 or 4 lanes for a byte, halfword or word.
- R8: Little-endian (byte order bit 0) maps address byte k to lane k, which is bits 8k+7:8k. Big-endian (bit 1) maps address byte k to lane 3-k. For a halfword, the enabled lanes are bits 15:0 when address bit 1 XOR the byte order bit is 0, and bits 31:16 otherwise.
- R9: ld_data takes from mem_rdata the lane or half selected by the same mapping as R8 for the access shown on the outputs, zero-extended. A word is passed unchanged.
- R10: A word access with address bits 1:0 not 00, or a halfword access with address bit 0 set, gives align_err=1, mem_be=0, mem_we=0 and base_wb_en=0.
- R11: The byte order is taken from cfg_big_endian while rst_n is low. Later changes of cfg_big_endian have no effect on the lane mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_big_endian | input | 1 | Byte order setting, captured during reset (1 = big-endian) |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| base_val | input | 32 | Base register value |
| off_reg | input | 32 | Register offset value |
| off_imm | input | IMM_W | Immediate offset, zero-extended |
| off_is_reg | input | 1 | Offset source select (1 = register) |
| off_sub | input | 1 | 1 = subtract offset, 0 = add |
| pre_index | input | 1 | 1 = pre-indexed or plain offset, 0 = post-indexed |
| writeback | input | 1 | Base update request for pre-indexed access |
| store_data | input | 32 | Store value in register form |
| mem_rdata | input | 32 | Word returned by memory for the shown load |
| out_valid | output | 1 | Outputs carry a request result |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte-lane enables |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Lane-aligned store data |
| align_err | output | 1 | Misaligned access flag |
| ld_data | output | 32 | Extracted, zero-extended load value |
| base_wb_val | output | 32 | Updated base value |
| base_wb_en | output | 1 | Base register write strobe |

## Verification
Address, lane enable, write data, error and base update results are due one rising edge after the request is sampled. The bench drives each request on a falling edge and reads the outputs 1 ns after the next rising edge, then drops the request before the following edge. ld_data has no register of its own. The bench changes mem_rdata only while a load result is held on the outputs and reads ld_data 1 ns later in the same cycle. Byte order tests apply a fresh reset with the setting driven, then flip the setting after reset to show that the mapping holds.

// File: rtl/mal_pkg.sv
package mal_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_AW = $clog2(LANES);

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              we;
        logic              err;
        logic [DATA_W-1:0] wb_val;
        logic              wb_en;
        acc_size_e         size;
    } stage_t;
endpackage

// File: rtl/mal_addr_gen.sv
module mal_addr_gen
    import mal_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] off_reg,
    input  logic [IMM_W-1:0]  off_imm,
    input  logic              off_is_reg,
    input  logic              off_sub,
    input  logic              pre_index,
    input  logic              writeback,
    output logic [DATA_W-1:0] acc_addr,
    output logic [DATA_W-1:0] new_base,
    output logic              base_upd
);
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] indexed;

    always_comb begin
        offset   = off_is_reg ? off_reg : {{(DATA_W-IMM_W){1'b0}}, off_imm};
        indexed  = off_sub ? (base_val - offset) : (base_val + offset);
        acc_addr = pre_index ? indexed : base_val;
        new_base = indexed;
        // post-indexed always updates; pre-indexed only on request
        base_upd = !pre_index || writeback;
    end
endmodule

// File: rtl/mal_lane_steer.sv
module mal_lane_steer
    import mal_pkg::*;
(
    input  acc_size_e          size,
    input  logic [LANE_AW-1:0] lane,
    input  logic               big,
    input  logic [DATA_W-1:0]  sdata,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  wdata,
    output logic               misalign
);
    logic [LANE_AW-1:0] byte_lane;
    logic               half_hi;
    logic [LANES-1:0]   be_raw;

    always_comb begin
        byte_lane = big ? (LANE_AW'(LANES - 1) - lane) : lane;
        half_hi   = lane[1] ^ big;
        unique case (size)
            ACC_BYTE: misalign = 1'b0;
            ACC_HALF: misalign = lane[0];
            default:  misalign = |lane;
        endcase
        unique case (size)
            ACC_BYTE: be_raw = LANES'(1) << byte_lane;
            ACC_HALF: be_raw = half_hi ? 4'b1100 : 4'b0011;
            default:  be_raw = '1;
        endcase
        be = misalign ? '0 : be_raw;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                ACC_BYTE: wdata[8*i +: 8] = sdata[7:0];
                ACC_HALF: wdata[8*i +: 8] = sdata[8*(i%2) +: 8];
                default:  wdata[8*i +: 8] = sdata[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/mal_load_extract.sv
module mal_load_extract
    import mal_pkg::*;
(
    input  acc_size_e          size,
    input  logic [LANE_AW-1:0] lane,
    input  logic               big,
    input  logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  ldata
);
    logic [LANE_AW-1:0] byte_lane;
    logic [DATA_W-1:0]  shifted;

    always_comb begin
        byte_lane = big ? (LANE_AW'(LANES - 1) - lane) : lane;
        shifted   = rdata >> {byte_lane, 3'b000};
        unique case (size)
            ACC_BYTE: ldata = {{(DATA_W-8){1'b0}}, shifted[7:0]};
            ACC_HALF: ldata = (lane[1] ^ big) ? {16'h0, rdata[31:16]}
                                              : {16'h0, rdata[15:0]};
            default:  ldata = rdata;
        endcase
    end
endmodule

// File: rtl/mem_access_align.sv
module mem_access_align
    import mal_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic [31:0]       base_val,
    input  logic [31:0]       off_reg,
    input  logic [IMM_W-1:0]  off_imm,
    input  logic              off_is_reg,
    input  logic              off_sub,
    input  logic              pre_index,
    input  logic              writeback,
    input  logic [31:0]       store_data,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    output logic              align_err,
    output logic [31:0]       ld_data,
    output logic [31:0]       base_wb_val,
    output logic              base_wb_en
);
    stage_t st_d, st_q;
    logic   endian_d, endian_q;

    logic [DATA_W-1:0] acc_addr, new_base;
    logic              base_upd;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_wdata;
    logic              misalign;
    acc_size_e         size_in;

    assign size_in = acc_size_e'(req_size);

    mal_addr_gen #(.IMM_W(IMM_W)) u_agen (
        .base_val   (base_val),
        .off_reg    (off_reg),
        .off_imm    (off_imm),
        .off_is_reg (off_is_reg),
        .off_sub    (off_sub),
        .pre_index  (pre_index),
        .writeback  (writeback),
        .acc_addr   (acc_addr),
        .new_base   (new_base),
        .base_upd   (base_upd)
    );

    mal_lane_steer u_steer (
        .size     (size_in),
        .lane     (acc_addr[LANE_AW-1:0]),
        .big      (endian_q),
        .sdata    (store_data),
        .be       (lane_be),
        .wdata    (lane_wdata),
        .misalign (misalign)
    );

    mal_load_extract u_ldx (
        .size  (st_q.size),
        .lane  (st_q.addr[LANE_AW-1:0]),
        .big   (endian_q),
        .rdata (mem_rdata),
        .ldata (ld_data)
    );

    always_comb begin
        endian_d    = rst_n ? endian_q : cfg_big_endian;
        st_d        = '0;
        st_d.addr   = acc_addr;
        st_d.wdata  = lane_wdata;
        st_d.wb_val = new_base;
        st_d.size   = size_in;
        if (req_valid) begin
            st_d.vld   = 1'b1;
            st_d.err   = misalign;
            st_d.be    = lane_be;
            st_d.we    = req_store && !misalign;
            st_d.wb_en = base_upd && !misalign;
        end
    end

    always_ff @(posedge clk) begin
        endian_q <= endian_d;
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign mem_addr    = st_q.addr;
    assign mem_be      = st_q.be;
    assign mem_we      = st_q.we;
    assign mem_wdata   = st_q.wdata;
    assign align_err   = st_q.err;
    assign base_wb_val = st_q.wb_val;
    assign base_wb_en  = st_q.wb_en;
endmodule

// File: rtl/mal_checker.sv
module mal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        pre_index,
    input logic        writeback,
    input logic [31:0] base_val,
    input logic        out_valid,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        mem_we,
    input logic        align_err,
    input logic        base_wb_en,
    input logic        endian_q
);
    a_r2_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r2_idle_no_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && mem_be == 4'b0 && !mem_we && !base_wb_en));

    a_r3_no_update_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pre_index && !writeback) |=> !base_wb_en);

    a_r5_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pre_index) |=> (mem_addr == $past(base_val)));

    a_r7_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                    || $countones(mem_be) == 4));

    a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (mem_be == 4'b0 && !mem_we && !base_wb_en));

    a_r11_order_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(endian_q));
endmodule

bind mem_access_align mal_checker u_chk (.*);

// File: tb/mem_access_align_bench.sv
`timescale 1ns/1ps
module mem_access_align_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] base_val = '0;
    logic [31:0] off_reg = '0;
    logic [11:0] off_imm = '0;
    logic        off_is_reg = 1'b0;
    logic        off_sub = 1'b0;
    logic        pre_index = 1'b1;
    logic        writeback = 1'b0;
    logic [31:0] store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, mem_we, align_err, base_wb_en;
    logic [31:0] mem_addr, mem_wdata, ld_data, base_wb_val;
    logic [3:0]  mem_be;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mem_access_align u_mem_access_align (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic big);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        cfg_big_endian = big;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(logic st, logic [1:0] sz, logic [31:0] base,
                         logic isreg, logic [31:0] roff, logic [11:0] imm,
                         logic sub, logic pre, logic wb, logic [31:0] sd);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; base_val = base;
        off_is_reg = isreg; off_reg = roff; off_imm = imm; off_sub = sub;
        pre_index = pre; writeback = wb; store_data = sd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 mem_be", 32'(mem_be), 0);
        chk("R1 base_wb_en", 32'(base_wb_en), 0);
        chk("R1 align_err", 32'(align_err), 0);
        chk("R1 mem_we", 32'(mem_we), 0);
    endtask

    task automatic t_plain_offset;
        issue(0, 2'b10, 32'h1000, 0, 0, 12'h010, 0, 1, 0, 0);
        chk("R2 out_valid", 32'(out_valid), 1);
        chk("R3 addr", mem_addr, 32'h1010);
        chk("R3 no wb", 32'(base_wb_en), 0);
        chk("R7 word be", 32'(mem_be), 32'hF);
        @(posedge clk); #1;
        chk("R2 idle valid", 32'(out_valid), 0);
        chk("R2 idle be", 32'(mem_be), 0);
    endtask

    task automatic t_offset_forms;
        issue(0, 2'b10, 32'h1000, 1, 32'h20, 12'hFFF, 1, 1, 0, 0);
        chk("R6 reg sub", mem_addr, 32'h0FE0);
        issue(0, 2'b10, 32'h4, 0, 32'h8, 12'h008, 1, 1, 0, 0);
        chk("R6 wrap", mem_addr, 32'hFFFF_FFFC);
        issue(0, 2'b10, 32'h100, 0, 0, 12'hFFC, 0, 1, 0, 0);
        chk("R6 imm zero-ext", mem_addr, 32'h10FC);
    endtask

    task automatic t_pre_wb;
        issue(1, 2'b10, 32'h2000, 0, 0, 12'h004, 0, 1, 1, 32'hDEAD_BEEF);
        chk("R4 addr", mem_addr, 32'h2004);
        chk("R4 wb val", base_wb_val, 32'h2004);
        chk("R4 wb en", 32'(base_wb_en), 1);
        chk("R7 we", 32'(mem_we), 1);
        chk("R7 word data", mem_wdata, 32'hDEAD_BEEF);
    endtask

    task automatic t_post;
        issue(0, 2'b10, 32'h3000, 1, 32'h100, 0, 0, 0, 0, 0);
        chk("R5 addr", mem_addr, 32'h3000);
        chk("R5 wb val", base_wb_val, 32'h3100);
        chk("R5 wb en", 32'(base_wb_en), 1);
    endtask

    task automatic t_little;
        issue(1, 2'b00, 32'h41, 0, 0, 0, 0, 1, 0, 32'h1234_56A5);
        chk("R8 LE byte be", 32'(mem_be), 32'h2);
        chk("R7 byte repl", mem_wdata, 32'hA5A5_A5A5);
        issue(1, 2'b01, 32'h42, 0, 0, 0, 0, 1, 0, 32'h0000_BEEF);
        chk("R8 LE half be", 32'(mem_be), 32'hC);
        chk("R7 half repl", mem_wdata, 32'hBEEF_BEEF);
        issue(0, 2'b00, 32'h43, 0, 0, 0, 0, 1, 0, 0);
        mem_rdata = 32'h1122_3344; #1;
        chk("R9 LE byte load", ld_data, 32'h11);
        issue(0, 2'b01, 32'h42, 0, 0, 0, 0, 1, 0, 0);
        #1;
        chk("R9 LE half load", ld_data, 32'h1122);
        issue(0, 2'b10, 32'h40, 0, 0, 0, 0, 1, 0, 0);
        #1;
        chk("R9 word load", ld_data, 32'h1122_3344);
    endtask

    task automatic t_misalign;
        issue(1, 2'b10, 32'h1002, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 word err", 32'(align_err), 1);
        chk("R10 word be", 32'(mem_be), 0);
        chk("R10 word we", 32'(mem_we), 0);
        chk("R10 word wb", 32'(base_wb_en), 0);
        issue(0, 2'b01, 32'h1001, 0, 0, 0, 0, 1, 1, 0);
        chk("R10 half err", 32'(align_err), 1);
        chk("R10 half wb", 32'(base_wb_en), 0);
        issue(0, 2'b00, 32'h1003, 0, 0, 0, 0, 1, 0, 0);
        chk("R10 byte ok", 32'(align_err), 0);
    endtask

    task automatic t_big;
        do_reset(1'b1);
        cfg_big_endian = 1'b0;
        issue(1, 2'b00, 32'h1, 0, 0, 0, 0, 1, 0, 32'h77);
        chk("R8 BE byte be", 32'(mem_be), 32'h4);
        issue(1, 2'b01, 32'h0, 0, 0, 0, 0, 1, 0, 32'h5566);
        chk("R8 BE half be", 32'(mem_be), 32'hC);
        issue(0, 2'b00, 32'h0, 0, 0, 0, 0, 1, 0, 0);
        mem_rdata = 32'h1122_3344; #1;
        chk("R9 BE byte load", ld_data, 32'h11);
        issue(0, 2'b01, 32'h2, 0, 0, 0, 0, 1, 0, 0);
        #1;
        chk("R9 BE half load", ld_data, 32'h3344);
        issue(0, 2'b00, 32'h0, 0, 0, 0, 0, 1, 0, 0);
        chk("R11 order held", 32'(mem_be), 32'h8);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_plain_offset();
        t_offset_forms();
        t_pre_wb();
        t_post();
        t_little();
        t_misalign();
        t_big();
        finish_run();
    end
endmodule